// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block is the power-control piece of an always-on real-time-clock domain and runs on the slow domain clock. Software writes a request bit to drop the chip into hibernation. The block then deasserts the main power-enable output and holds the system reset low. While the chip is down, the block watches an active-low wakeup pin. The pin passes through a two-flop synchroniser and then through a qualification counter, which rejects short glitches.

Once the pin has stayed asserted for the programmed number of ticks, power is turned back on. The system reset is held low for a second programmed number of ticks and then released, which returns the sequencer to normal running. Both tick counts are stored with coarse granularity: the low five bits of each count are always zero. A qualification count of 0 wakes the chip on the first synchronised asserted sample. A reset hold count of 0 gives a reset pulse of a single cycle.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset the sequencer is running: `pwrEn` = 1 and `sysRstN` = 1. The filter register reads 0x000007A0 and the hold register reads 0x00000CC0.
- R2: In the running state, a write to offset 0x20 with data bit 0 = 1 drives both `pwrEn` and `sysRstN` low at the clock edge that takes the write. A write to 0x20 with bit 0 = 0 has no effect.
- R3: A write of 1 to offset 0x20 while hibernating or while holding reset is ignored. The sequence continues and power stays as it was.
- R4: The filter register at offset 0x24 stores only data bits 15:5. Reads of 0x24 return those bits and return 0 in every other position.
- R5: The hold register at offset 0x28 stores only data bits 11:5, and reads return 0 in every other position. Reads of offset 0x20 and of any unmapped offset return 0.
- R6: While hibernating with filter value F, power returns once F+1 consecutive synchronised samples show `wakeN` low. If `wakeN` is first driven low in the cycle after edge N and stays low, `pwrEn` rises at edge N+3+F.
- R7: If `wakeN` goes high before the qualification completes, the count restarts from zero. Two low pulses of F samples each, with a gap between them, do not wake the chip.
- R8: After a wake with hold value H, `sysRstN` stays low for H+1 cycles with power on and rises at edge N+4+F+H. With H = 0, reset is low for exactly one cycle.
- R9: Activity on `wakeN` in the running state changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on domain clock |
| rstN | input | 1 | Asynchronous active-low reset of the domain |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Read data (combinational from rdAddr) |
| wakeN | input | 1 | Asynchronous active-low wakeup pin |
| pwrEn | output | 1 | Main power enable, high when powered |
| sysRstN | output | 1 | Active-low system reset |

## Verification
The qualification path is tested first with a zero filter count, which shows whether the synchroniser latency is counted correctly. It is then tested with two low pulses that each stop exactly one sample short of the threshold, separated by a gap. This tells a counter that restarts from zero apart from one that only pauses or keeps accumulating. The reset hold is tested at zero and at its largest stored value, which separates off-by-one errors in the hold length and shows whether the masked low bits leak in. Pin activity in the running state and hibernate writes during the hold phase show that the pin and the request register are each acted on only in their own phase.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HIB  = 2'd1,
    ST_HOLD = 2'd2
  } seqState_e;

  typedef struct packed {
    logic filtInc;
    logic filtClr;
    logic holdInc;
    logic holdClr;
  } seqStrobe_t;

endpackage

// File: rtl/hib_pin_sync.sv
module hib_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RST_VAL;
    else       chain[0] <= pinIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RST_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign pinOut = chain[STAGES-1];

endmodule

// File: rtl/hib_seq_datapath.sv
module hib_seq_datapath
  import hib_seq_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] OFS_HIB      = 'h20,
  parameter logic [ADDR_W-1:0] OFS_FILT     = 'h24,
  parameter logic [ADDR_W-1:0] OFS_HOLD     = 'h28,
  parameter int                FILT_MSB     = 15,
  parameter int                HOLD_MSB     = 11,
  parameter int                GRAIN_LSB    = 5,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] FILT_RST_VAL = 'h07A0,
  parameter logic [DATA_W-1:0] HOLD_RST_VAL = 'h0CC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wakeN,
  input  seqStrobe_t        strobe,
  output logic              wakeAsserted,
  output logic              filtDone,
  output logic              holdDone,
  output logic              hibReq
);

  localparam int FILT_W = FILT_MSB + 1;
  localparam int HOLD_W = HOLD_MSB + 1;

  logic [FILT_MSB:GRAIN_LSB] filtField;
  logic [HOLD_MSB:GRAIN_LSB] holdField;
  logic [FILT_W-1:0]         filtLimit;
  logic [HOLD_W-1:0]         holdLimit;
  logic [FILT_W-1:0]         filtCnt;
  logic [HOLD_W-1:0]         holdCnt;
  logic                      wakeSync;
  logic                      unusedWrBits;

  assign unusedWrBits = ^wrData;

  hib_pin_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) uSync (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (wakeN),
    .pinOut(wakeSync)
  );

  assign wakeAsserted = !wakeSync;

  // Register file: coarse count fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtField <= FILT_RST_VAL[FILT_MSB:GRAIN_LSB];
      holdField <= HOLD_RST_VAL[HOLD_MSB:GRAIN_LSB];
    end else if (wrEn) begin
      if (wrAddr == OFS_FILT) filtField <= wrData[FILT_MSB:GRAIN_LSB];
      if (wrAddr == OFS_HOLD) holdField <= wrData[HOLD_MSB:GRAIN_LSB];
    end
  end

  assign hibReq = wrEn && (wrAddr == OFS_HIB) && wrData[0];

  always_comb begin
    rdData = '0;
    if (rdAddr == OFS_FILT) rdData[FILT_MSB:GRAIN_LSB] = filtField;
    else if (rdAddr == OFS_HOLD) rdData[HOLD_MSB:GRAIN_LSB] = holdField;
  end

  assign filtLimit = {filtField, {GRAIN_LSB{1'b0}}};
  assign holdLimit = {holdField, {GRAIN_LSB{1'b0}}};

  // Qualification and hold counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                filtCnt <= '0;
    else if (strobe.filtClr)  filtCnt <= '0;
    else if (strobe.filtInc)  filtCnt <= filtCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobe.holdClr)  holdCnt <= '0;
    else if (strobe.holdInc)  holdCnt <= holdCnt + 1'b1;
  end

  assign filtDone = (filtCnt >= filtLimit);
  assign holdDone = (holdCnt >= holdLimit);

  AST_FILT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !wakeAsserted |=> (filtCnt == '0)); // R7

  AST_FILT_RD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == OFS_FILT) |-> (rdData[GRAIN_LSB-1:0] == '0 && rdData[DATA_W-1:FILT_W] == '0)); // R4

endmodule

// File: rtl/hib_seq_ctrl.sv
module hib_seq_ctrl
  import hib_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hibReq,
  input  logic       wakeAsserted,
  input  logic       filtDone,
  input  logic       holdDone,
  output seqStrobe_t strobe,
  output logic       pwrEn,
  output logic       sysRstN
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:  if (hibReq) nextState = ST_HIB;
      ST_HIB:  if (wakeAsserted && filtDone) nextState = ST_HOLD;
      ST_HOLD: if (holdDone) nextState = ST_RUN;
      default: nextState = ST_RUN;
    endcase
  end

  always_comb begin
    strobe.filtInc = (state == ST_HIB) && wakeAsserted && !filtDone;
    strobe.filtClr = !((state == ST_HIB) && wakeAsserted);
    strobe.holdInc = (state == ST_HOLD) && !holdDone;
    strobe.holdClr = (state != ST_HOLD);
  end

  assign pwrEn   = (state != ST_HIB);
  assign sysRstN = (state == ST_RUN);

  AST_HIB_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> ($past(state) == ST_RUN && $past(hibReq))); // R2

  AST_HOLD_IGNORES_HIB: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && hibReq) |=> pwrEn); // R3

  AST_WAKE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) == ST_HIB) |-> $past(wakeAsserted)); // R6

  AST_RST_AFTER_PWR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> $past(pwrEn)); // R8

endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
  import hib_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wakeN,
  output logic              pwrEn,
  output logic              sysRstN
);

  seqStrobe_t strobe;
  logic       wakeAsserted;
  logic       filtDone;
  logic       holdDone;
  logic       hibReq;

  hib_seq_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .wakeN       (wakeN),
    .strobe      (strobe),
    .wakeAsserted(wakeAsserted),
    .filtDone    (filtDone),
    .holdDone    (holdDone),
    .hibReq      (hibReq)
  );

  hib_seq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .hibReq      (hibReq),
    .wakeAsserted(wakeAsserted),
    .filtDone    (filtDone),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .pwrEn       (pwrEn),
    .sysRstN     (sysRstN)
  );

endmodule

// File: tb/tb_hib_wake_seq.sv
module tb_hib_wake_seq;

  localparam logic [7:0] A_HIB  = 8'h20;
  localparam logic [7:0] A_FILT = 8'h24;
  localparam logic [7:0] A_HOLD = 8'h28;

  typedef struct {
    int unsigned cyc;
    logic        pwr;
    logic        rst;
    string       tag;
  } expEvt_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wakeN = 1'b1;
  logic        pwrEn;
  logic        sysRstN;

  int unsigned cyc = 0;
  int          nChecks = 0;
  int          nFail = 0;
  expEvt_t     expQ[$];
  logic [1:0]  prevOut = 2'b11;

  hib_wake_seq dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wakeN  (wakeN),
    .pwrEn  (pwrEn),
    .sysRstN(sysRstN)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkRead(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  // Driver: request hibernate, expecting both outputs low at the next edge
  task automatic hibernate(input string tag);
    @(negedge clk);
    expQ.push_back('{cyc + 1, 1'b0, 1'b0, tag});
    wrEn = 1'b1; wrAddr = A_HIB; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: hold the pin low and predict power-up and reset release
  task automatic startWake(input int f, input int h);
    @(negedge clk);
    expQ.push_back('{cyc + 3 + f, 1'b1, 1'b0, "R6"});
    expQ.push_back('{cyc + 4 + f + h, 1'b1, 1'b1, "R8"});
    wakeN = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    wakeN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: every output change must match the head of the queue
  always @(negedge clk) begin
    if (rstN && ({pwrEn, sysRstN} != prevOut)) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL unexpected output change (R2/R3/R7/R9) actual=%b expected=%b at cycle %0d",
                 {pwrEn, sysRstN}, prevOut, cyc);
      end else begin
        expEvt_t e;
        e = expQ.pop_front();
        check({e.tag, " event cycle"}, cyc, e.cyc);
        check({e.tag, " event outputs"}, {30'd0, pwrEn, sysRstN}, {30'd0, e.pwr, e.rst});
      end
      prevOut = {pwrEn, sysRstN};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwrEn", {31'd0, pwrEn}, 32'd1);
    check("R1 sysRstN", {31'd0, sysRstN}, 32'd1);
    checkRead("R1 filter reset", A_FILT, 32'h0000_07A0);
    checkRead("R1 hold reset", A_HOLD, 32'h0000_0CC0);

    // R4 / R5 field masking
    regWrite(A_FILT, 32'hFFFF_FFFF);
    checkRead("R4 filter mask", A_FILT, 32'h0000_FFE0);
    regWrite(A_HOLD, 32'hFFFF_FFFF);
    checkRead("R5 hold mask", A_HOLD, 32'h0000_0FE0);
    checkRead("R5 hibernate reads zero", A_HIB, 32'h0);
    checkRead("R5 unmapped reads zero", 8'h2C, 32'h0);

    // R9 pin activity while running
    @(negedge clk); wakeN = 1'b0;
    repeat (10) @(negedge clk);
    wakeN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 outputs while running", {30'd0, pwrEn, sysRstN}, 32'd3);

    // R2 write of zero ignored
    regWrite(A_HIB, 32'h0);
    repeat (2) @(negedge clk);
    check("R2 zero write ignored", {31'd0, pwrEn}, 32'd1);

    // Zero filter and zero hold
    regWrite(A_FILT, 32'h0000_001F);
    checkRead("R4 low bits dropped", A_FILT, 32'h0);
    regWrite(A_HOLD, 32'h0);
    hibernate("R2");
    regWrite(A_HIB, 32'h1);   // R3: ignored while hibernating
    repeat (3) @(negedge clk);
    check("R3 still hibernating", {30'd0, pwrEn, sysRstN}, 32'd0);
    startWake(0, 0);
    drain();

    // Glitch rejection, F=64, H=32
    regWrite(A_FILT, 32'h40);
    regWrite(A_HOLD, 32'h20);
    hibernate("R2");
    @(negedge clk); wakeN = 1'b0;
    repeat (64) @(negedge clk);
    wakeN = 1'b1;
    repeat (3) @(negedge clk);
    wakeN = 1'b0;
    repeat (64) @(negedge clk);
    wakeN = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 no wake after split pulses", {31'd0, pwrEn}, 32'd0);
    startWake(64, 32);
    while (expQ.size() != 1) @(negedge clk);
    regWrite(A_HIB, 32'h1);   // R3: ignored while holding reset
    check("R3 hold phase unaffected", {30'd0, pwrEn, sysRstN}, 32'd2);
    drain();

    // Largest hold
    regWrite(A_FILT, 32'h20);
    regWrite(A_HOLD, 32'hFFFF_FFFF);
    hibernate("R2");
    startWake(32, 4064);
    drain();

    check("queue drained", expQ.size(), 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule